// File: doc/BRIEF.md
# Media-Change Flag Latch

This block holds the media-changed indication of one floppy drive and returns it to the host in the top bit of the drive's digital input register. It watches three things: a level that is high while a diskette is in the drive, a one-cycle pulse from the seek logic each time the head really moves one track, and a host read port. The flag warns software that the diskette it last saw may be gone or may have been swapped.

The flag is sticky. A falling edge on the media level sets it, and so does reset. Only a head step taken while a diskette is seated clears it. Reading the register does not clear it, and inserting a diskette does not clear it. A seek to the cylinder the head already sits on issues no step pulse, so it leaves the flag alone. The media level is taken from a registered copy of the input. A diskette therefore counts as seated from the cycle after the level rises. Every other bit of the register, and every other register offset, reads as zero.

Top module: `disk_change_latch`

## Requirements
- R1: While reset is asserted, and after it is released, the flag is set whatever the media level. After reset the read data output is 0x00.
- R2: A read (rd_en_i high at a clock edge) with rd_addr_i = 7 loads rd_data_o with the flag in bit 7 and zeros in bits 6..0, visible after that edge. rd_data_o then holds its value until the next read, even if the flag changes.
- R3: A read at any offset other than 7 returns 0x00.
- R4: Reading the register any number of times leaves the flag unchanged.
- R5: Raising the media level does not clear the flag.
- R6: A step pulse clears the flag when media was present in the previous cycle and is still present.
- R7: Cycles with no step pulse leave a set flag set, even with media present.
- R8: A falling edge on the media level sets the flag.
- R9: Step pulses while no media is present leave the flag set.
- R10: If a step pulse comes in the same cycle as the media level falls, the flag ends up set.
- R11: A step pulse in the same cycle that the media level first rises does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| media_present_i | input | 1 | High while a diskette is in the drive |
| step_pulse_i | input | 1 | One-cycle pulse for each head step |
| rd_en_i | input | 1 | Host register read strobe |
| rd_addr_i | input | 3 | Register offset of the read |
| rd_data_o | output | 8 | Registered read data |

## Verification
The only internal state visible at the ports is the flag and the registered copy of the media level. A flag in the wrong state shows up in bit 7 on the very next read at offset 7. It can stay hidden for as long as software does not read. A stale or inverted copy of the media level shows up one step later. Either a step just after insertion wrongly clears the flag, or a removal fails to set it. So each scenario reads the register right after every event and again after a later step.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_SET   = 2'd1,
    EV_CLEAR = 2'd2
  } flag_event_e;
endpackage

// File: rtl/dcl_reset_sync.sv
module dcl_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dcl_media_edge.sv
module dcl_media_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic media_i,
  output logic media_q,
  output logic removed
);
  logic level_q;
  logic level_d;

  always_comb begin
    level_d = media_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_d;
  end

  assign media_q = level_q;
  assign removed = level_q & ~media_i;
endmodule

// File: rtl/dcl_flag_latch.sv
module dcl_flag_latch
  import dcl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic removed,
  input  logic media_q,
  input  logic media_i,
  input  logic step_i,
  output logic flag
);
  flag_event_e ev;
  logic        flag_q;
  logic        flag_d;
  logic        flag_en;

  always_comb begin
    if (removed)                           ev = EV_SET;
    else if (step_i && media_q && media_i) ev = EV_CLEAR;
    else                                   ev = EV_NONE;
  end

  always_comb begin
    flag_en = (ev != EV_NONE);
    flag_d  = (ev == EV_SET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b1;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/dcl_read_port.sv
module dcl_read_port #(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 8,
  parameter int REG_OFFSET = 7,
  parameter int FLAG_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              flag,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_d;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == FLAG_BIT) begin : g_flag
      assign word[i] = flag;
    end else begin : g_zero
      assign word[i] = 1'b0;
    end
  end

  always_comb begin
    data_d = (rd_addr == HIT_ADDR) ? word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (rd_en) data_q <= data_d;
  end

  assign rd_data = data_q;
endmodule

// File: rtl/disk_change_latch.sv
module disk_change_latch #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int REG_OFFSET  = 7,
  parameter int FLAG_BIT    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              media_present_i,
  input  logic              step_pulse_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic rst_sync_n;
  logic media_q;
  logic removed;
  logic flag;

  dcl_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dcl_media_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .media_i (media_present_i),
    .media_q (media_q),
    .removed (removed)
  );

  dcl_flag_latch u_flag (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .removed (removed),
    .media_q (media_q),
    .media_i (media_present_i),
    .step_i  (step_pulse_i),
    .flag    (flag)
  );

  dcl_read_port #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .REG_OFFSET (REG_OFFSET),
    .FLAG_BIT   (FLAG_BIT)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_en   (rd_en_i),
    .rd_addr (rd_addr_i),
    .flag    (flag),
    .rd_data (rd_data_o)
  );
endmodule

// File: rtl/dcl_checker.sv
module dcl_checker #(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 8,
  parameter int REG_OFFSET = 7,
  parameter int FLAG_BIT   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              media_i,
  input logic              media_q,
  input logic              step_i,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              flag
);
  localparam logic [DATA_W-1:0] OTHER_MASK = ~(DATA_W'(1) << FLAG_BIT);
  localparam logic [ADDR_W-1:0] HIT_ADDR   = ADDR_W'(REG_OFFSET);

  p_rd_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == HIT_ADDR) |=> rd_data[FLAG_BIT] == $past(flag));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  p_rd_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & OTHER_MASK) == '0);

  p_rd_other_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr != HIT_ADDR) |=> rd_data == '0);

  p_clear_needs_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> ($past(step_i) && $past(media_q) && $past(media_i)));

  p_set_needs_removal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(media_q) && !$past(media_i)));

  p_removal_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (media_q && !media_i) |=> flag);
endmodule

bind disk_change_latch dcl_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .REG_OFFSET (REG_OFFSET),
  .FLAG_BIT   (FLAG_BIT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .media_i (media_present_i),
  .media_q (media_q),
  .step_i  (step_pulse_i),
  .rd_en   (rd_en_i),
  .rd_addr (rd_addr_i),
  .rd_data (rd_data_o),
  .flag    (flag)
);

// File: tb/disk_change_latch_tb.sv
`timescale 1ns/1ps
module disk_change_latch_tb;
  logic       clk;
  logic       rst_n;
  logic       media;
  logic       step;
  logic       rd_en;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;

  int total;
  int bad;

  disk_change_latch u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .media_present_i (media),
    .step_pulse_i    (step),
    .rd_en_i         (rd_en),
    .rd_addr_i       (rd_addr),
    .rd_data_o       (rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v     = rd_data;
  endtask

  task automatic do_step();
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic set_media(input logic v);
    @(negedge clk);
    media = v;
    @(negedge clk);
  endtask

  task automatic apply_reset(input logic m);
    @(negedge clk);
    media = m;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic t_reset_no_media();
    logic [7:0] v;
    apply_reset(1'b0);
    check("R1 rd_data after reset", rd_data, 8'h00);
    do_read(3'd7, v);
    check("R1 flag set after reset", v, 8'h80);
  endtask

  task automatic t_other_offsets();
    logic [7:0] v;
    for (int a = 0; a < 7; a++) begin
      do_read(3'(a), v);
      check("R3 other offset", v, 8'h00);
    end
  endtask

  task automatic t_repeat_reads();
    logic [7:0] v;
    for (int i = 0; i < 3; i++) begin
      do_read(3'd7, v);
      check("R4 repeated read keeps flag", v, 8'h80);
    end
  endtask

  task automatic t_steps_no_media();
    logic [7:0] v;
    do_step();
    do_step();
    do_read(3'd7, v);
    check("R9 steps without media", v, 8'h80);
  endtask

  task automatic t_insert_then_step();
    logic [7:0] v;
    set_media(1'b1);
    do_read(3'd7, v);
    check("R5 insertion keeps flag", v, 8'h80);
    idle(5);
    do_read(3'd7, v);
    check("R7 no step keeps flag", v, 8'h80);
    do_step();
    do_read(3'd7, v);
    check("R6 step with media clears", v, 8'h00);
    do_read(3'd7, v);
    check("R4 read keeps cleared flag", v, 8'h00);
    do_read(3'd7, v);
    check("R2 bit layout cleared", v, 8'h00);
  endtask

  task automatic t_remove_and_hold();
    logic [7:0] v;
    set_media(1'b0);
    idle(2);
    check("R2 rd_data holds without read", rd_data, 8'h00);
    do_read(3'd7, v);
    check("R8 removal sets flag", v, 8'h80);
    do_step();
    do_read(3'd7, v);
    check("R9 step after removal", v, 8'h80);
  endtask

  task automatic t_step_on_insert_cycle();
    logic [7:0] v;
    @(negedge clk);
    media = 1'b1;
    step  = 1'b1;
    @(negedge clk);
    step = 1'b0;
    do_read(3'd7, v);
    check("R11 step on insertion cycle", v, 8'h80);
    do_step();
    do_read(3'd7, v);
    check("R6 later step clears", v, 8'h00);
  endtask

  task automatic t_remove_with_step();
    logic [7:0] v;
    @(negedge clk);
    media = 1'b0;
    step  = 1'b1;
    @(negedge clk);
    step = 1'b0;
    do_read(3'd7, v);
    check("R10 removal beats step", v, 8'h80);
  endtask

  task automatic t_reset_with_media();
    logic [7:0] v;
    set_media(1'b1);
    do_step();
    do_read(3'd7, v);
    check("R6 cleared before reset", v, 8'h00);
    apply_reset(1'b1);
    check("R1 rd_data after reset", rd_data, 8'h00);
    do_read(3'd7, v);
    check("R1 reset sets flag with media", v, 8'h80);
    do_step();
    do_read(3'd7, v);
    check("R6 step after reset clears", v, 8'h00);
  endtask

  initial begin
    total   = 0;
    bad     = 0;
    rst_n   = 1'b0;
    media   = 1'b0;
    step    = 1'b0;
    rd_en   = 1'b0;
    rd_addr = 3'd0;
    t_reset_no_media();
    t_other_offsets();
    t_repeat_reads();
    t_steps_no_media();
    t_insert_then_step();
    t_remove_and_hold();
    t_step_on_insert_cycle();
    t_remove_with_step();
    t_reset_with_media();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule